// File: doc/BRIEF.md
# Receive Descriptor Fill Engine

This block turns an announced incoming packet into a ready-to-consume chain of host descriptors. For every packet it takes free descriptors from a free-descriptor queue, one at a time. For each descriptor it reads the allocation size and buffer address that software stored in the descriptor's permanent fields. It then writes the working buffer pointer and the number of bytes that landed in that buffer. When the data is longer than one buffer, further descriptors are taken and linked through their next-pointer words, and the last one gets a zero link. The head descriptor also receives the packet header word and the packet-information word. When the whole chain is written, the head address is pushed to a destination queue.

The data copy into the buffers and the choice of which free queue or destination queue to use belong to neighbouring logic. The engine only owns the descriptor bookkeeping. Descriptors are 32 bytes long and 32-byte aligned. The memory port is a single synchronous port: read data appears on `mem_rdata` one clock after the read request.

Top module: `rxf_engine`

## Requirements
- R1: After reset `pkt_ready` is 1, `fq_pop`, `dq_push` and `mem_en` are 0, and `starve_cnt` is 0.
- R2: For every descriptor in a chain, word 3 (byte offset 12) is written with bits 21-0 equal to the bytes placed in that buffer and bits 31-22 equal to 0. The byte count is the smaller of the bytes still outstanding and the allocation size in bits 21-0 of word 6. Word 4 (offset 16) is written with the value of word 7 (offset 28).
- R3: Words 6 and 7 (offsets 24 and 28) of every descriptor are never written.
- R4: Word 5 (offset 20) of each descriptor holds the address of the next descriptor in the chain, and the final descriptor's word 5 is written with 0.
- R5: Word 0 of the head descriptor is written with bits 31-30 = 0, bits 29-25 = `pkt_type`, bits 24-23 = 0, bit 22 = `pkt_ps_loc` and bits 21-0 = `pkt_len`.
- R6: Word 2 (offset 8) of the head descriptor is written with bit 31 = `pkt_epib`, bit 30 = 0, bits 29-24 = `pkt_ps_words`, bits 23-16 = 0, and bits 15-0 kept from their previous content.
- R7: A packet uses the fewest descriptors, in pop order, that hold its length, and no fewer than one. A zero-length packet uses exactly one descriptor, whose word 3 is 0 and whose word 5 is 0.
- R8: The head descriptor address is pushed exactly once per packet, as a one-cycle `dq_push` pulse, and only after every word of the chain has been written.
- R9: While the free queue is empty the engine does not pop and waits without losing the packet. `starve_cnt` rises by exactly one for each separate waiting episode.
- R10: `pkt_ready` drops in the cycle after a packet is accepted and returns in the cycle after the push.
- R11: Words 0, 1 and 2 of non-head descriptors and word 1 of the head descriptor are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | A packet announcement is present |
| pkt_ready | output | 1 | Engine is idle and accepts an announcement |
| pkt_len | input | 22 | Total packet length in bytes |
| pkt_type | input | 5 | Packet type code for the head header word |
| pkt_ps_loc | input | 1 | Protocol-specific words location: 0 in descriptor, 1 in first buffer |
| pkt_epib | input | 1 | Extended 16-byte information block present |
| pkt_ps_words | input | 6 | Protocol-specific word count in 4-byte units (0 to 32) |
| fq_empty | input | 1 | Free-descriptor queue has nothing to give |
| fq_desc | input | 32 | Address of the free descriptor at the queue head |
| fq_pop | output | 1 | Takes `fq_desc` in this cycle |
| mem_en | output | 1 | Descriptor memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Byte address of the accessed word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one clock after a read |
| dq_push | output | 1 | Push of a finished chain to the destination queue |
| dq_desc | output | 32 | Head descriptor address being pushed |
| starve_cnt | output | CNT_W | Count of episodes spent waiting on an empty free queue |

## Verification
Random packets with lengths spread from empty to several buffers, over descriptors of random allocation size, try the split arithmetic and the linking. A wrong minimum or a wrong link order shows up as a word 3 or word 5 mismatch. Directed cases tell the edges apart: a zero-length packet, and a packet exactly one buffer long, which must not take a second descriptor. A packet that meets an empty free queue twice in mid-chain separates per-episode counting from per-cycle counting and shows that the chain still completes. Header and information words are checked with random type, location, block flag and word count, against random pre-existing content in the kept bits.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam int RXF_LEN_W = 22;
  localparam int RXF_AW    = 32;
  localparam int RXF_DW    = 32;

  // byte offsets of descriptor words
  localparam logic [RXF_AW-1:0] OFS_HDR   = 32'd0;
  localparam logic [RXF_AW-1:0] OFS_INFO  = 32'd8;
  localparam logic [RXF_AW-1:0] OFS_BLEN  = 32'd12;
  localparam logic [RXF_AW-1:0] OFS_BPTR  = 32'd16;
  localparam logic [RXF_AW-1:0] OFS_LINK  = 32'd20;
  localparam logic [RXF_AW-1:0] OFS_OLEN  = 32'd24;
  localparam logic [RXF_AW-1:0] OFS_OPTR  = 32'd28;

  typedef enum logic [3:0] {
    ST_IDLE, ST_POP, ST_RD_OLEN, ST_RD_OPTR, ST_WR_BLEN, ST_WR_BPTR,
    ST_WR_LINK, ST_RD_INFO, ST_WR_INFO, ST_WR_HDR, ST_WR_TAIL, ST_PUSH
  } rxf_state_e;

  function automatic logic [RXF_LEN_W-1:0] rxf_fill(
    input logic [RXF_LEN_W-1:0] left, input logic [RXF_LEN_W-1:0] cap);
    return (left < cap) ? left : cap;
  endfunction

  function automatic logic [RXF_DW-1:0] rxf_hdr_word(
    input logic [4:0] ptype, input logic ps_loc, input logic [RXF_LEN_W-1:0] len);
    return {2'b00, ptype, 2'b00, ps_loc, len};
  endfunction

  function automatic logic [RXF_DW-1:0] rxf_info_word(
    input logic epib, input logic [5:0] ps_words, input logic [RXF_DW-1:0] old);
    return {epib, 1'b0, ps_words, 8'h00, old[15:0]};
  endfunction

endpackage

// File: rtl/rxf_budget.sv
module rxf_budget
  import rxf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [RXF_LEN_W-1:0] load_len,
  input  logic                 commit,
  input  logic [RXF_LEN_W-1:0] cap,
  output logic [RXF_LEN_W-1:0] fill,
  output logic                 done
);

  logic [RXF_LEN_W-1:0] left_q;

  assign fill = rxf_fill(left_q, cap);
  assign done = (left_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)      left_q <= '0;
    else if (load)   left_q <= load_len;
    else if (commit) left_q <= left_q - fill;
  end

  // a buffer that is not filled to its size must end the packet
  AST_SHORT_IS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && (fill != cap)) |=> done); // R7

  AST_FILL_NOT_ABOVE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (left_q + $past(cap) >= $past(left_q))); // R2

endmodule

// File: rtl/rxf_starve.sv
module rxf_starve #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             waiting,
  input  logic             popped,
  output logic [CNT_W-1:0] cnt
);

  logic in_episode;
  wire  ev_new_episode = waiting && !in_episode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      in_episode <= 1'b0;
    end else if (popped) begin
      in_episode <= 1'b0;
    end else if (ev_new_episode) begin
      in_episode <= 1'b1;
      if (cnt != '1) cnt <= cnt + 1'b1;
    end
  end

  AST_STARVE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt) |-> (cnt == $past(cnt) + 1'b1)); // R9

  AST_STARVE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt) |-> $past(waiting)); // R9

endmodule

// File: rtl/rxf_seq.sv
module rxf_seq
  import rxf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pkt_valid,
  output logic                 pkt_ready,
  input  logic [RXF_LEN_W-1:0] pkt_len,
  input  logic [4:0]           pkt_type,
  input  logic                 pkt_ps_loc,
  input  logic                 pkt_epib,
  input  logic [5:0]           pkt_ps_words,
  input  logic                 fq_empty,
  input  logic [RXF_AW-1:0]    fq_desc,
  output logic                 fq_pop,
  output logic                 mem_en,
  output logic                 mem_we,
  output logic [RXF_AW-1:0]    mem_addr,
  output logic [RXF_DW-1:0]    mem_wdata,
  input  logic [RXF_DW-1:0]    mem_rdata,
  output logic                 dq_push,
  output logic [RXF_AW-1:0]    dq_desc,
  output logic                 bud_load,
  output logic                 bud_commit,
  output logic [RXF_LEN_W-1:0] bud_cap,
  input  logic [RXF_LEN_W-1:0] bud_fill,
  input  logic                 bud_done,
  output logic                 starve_wait
);

  rxf_state_e st_q, st_d;

  logic [RXF_AW-1:0]    cur_q, prev_q, head_q, bptr_q;
  logic [RXF_LEN_W-1:0] blen_q, len_q;
  logic [4:0]           type_q;
  logic                 loc_q, epib_q, first_q, is_head_q;
  logic [5:0]           ps_q;

  wire ev_accept = pkt_valid && pkt_ready;
  wire ev_pop    = (st_q == ST_POP) && !fq_empty;
  wire ev_commit = (st_q == ST_WR_BLEN);
  wire ev_push   = (st_q == ST_PUSH);

  assign pkt_ready   = (st_q == ST_IDLE);
  assign fq_pop      = ev_pop;
  assign dq_push     = ev_push;
  assign dq_desc     = head_q;
  assign bud_load    = ev_accept;
  assign bud_commit  = ev_commit;
  assign bud_cap     = blen_q;
  assign starve_wait = (st_q == ST_POP) && fq_empty;

  // next state
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (pkt_valid) st_d = ST_POP;
      ST_POP:     if (!fq_empty) st_d = ST_RD_OLEN;
      ST_RD_OLEN: st_d = ST_RD_OPTR;
      ST_RD_OPTR: st_d = ST_WR_BLEN;
      ST_WR_BLEN: st_d = ST_WR_BPTR;
      ST_WR_BPTR: st_d = is_head_q ? ST_RD_INFO : ST_WR_LINK;
      ST_RD_INFO: st_d = ST_WR_INFO;
      ST_WR_INFO: st_d = ST_WR_HDR;
      ST_WR_HDR,
      ST_WR_LINK: st_d = bud_done ? ST_WR_TAIL : ST_POP;
      ST_WR_TAIL: st_d = ST_PUSH;
      ST_PUSH:    st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  // memory port
  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur_q;
    mem_wdata = '0;
    unique case (st_q)
      ST_RD_OLEN: begin mem_en = 1'b1; mem_addr = cur_q + OFS_OLEN; end
      ST_RD_OPTR: begin mem_en = 1'b1; mem_addr = cur_q + OFS_OPTR; end
      ST_RD_INFO: begin mem_en = 1'b1; mem_addr = cur_q + OFS_INFO; end
      ST_WR_BLEN: begin
        mem_en = 1'b1; mem_we = 1'b1; mem_addr = cur_q + OFS_BLEN;
        mem_wdata = {{(RXF_DW-RXF_LEN_W){1'b0}}, bud_fill};
      end
      ST_WR_BPTR: begin
        mem_en = 1'b1; mem_we = 1'b1; mem_addr = cur_q + OFS_BPTR;
        mem_wdata = bptr_q;
      end
      ST_WR_LINK: begin
        mem_en = 1'b1; mem_we = 1'b1; mem_addr = prev_q + OFS_LINK;
        mem_wdata = cur_q;
      end
      ST_WR_INFO: begin
        mem_en = 1'b1; mem_we = 1'b1; mem_addr = cur_q + OFS_INFO;
        mem_wdata = rxf_info_word(epib_q, ps_q, mem_rdata);
      end
      ST_WR_HDR: begin
        mem_en = 1'b1; mem_we = 1'b1; mem_addr = cur_q + OFS_HDR;
        mem_wdata = rxf_hdr_word(type_q, loc_q, len_q);
      end
      ST_WR_TAIL: begin
        mem_en = 1'b1; mem_we = 1'b1; mem_addr = cur_q + OFS_LINK;
        mem_wdata = '0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cur_q     <= '0;
      prev_q    <= '0;
      head_q    <= '0;
      bptr_q    <= '0;
      blen_q    <= '0;
      len_q     <= '0;
      type_q    <= '0;
      loc_q     <= 1'b0;
      epib_q    <= 1'b0;
      ps_q      <= '0;
      first_q   <= 1'b0;
      is_head_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (ev_accept) begin
        len_q   <= pkt_len;
        type_q  <= pkt_type;
        loc_q   <= pkt_ps_loc;
        epib_q  <= pkt_epib;
        ps_q    <= pkt_ps_words;
        first_q <= 1'b1;
      end
      if (ev_pop) begin
        prev_q    <= cur_q;
        cur_q     <= fq_desc;
        is_head_q <= first_q;
        first_q   <= 1'b0;
        if (first_q) head_q <= fq_desc;
      end
      if (st_q == ST_RD_OPTR) blen_q <= mem_rdata[RXF_LEN_W-1:0];
      if (st_q == ST_WR_BLEN) bptr_q <= mem_rdata;
    end
  end

  AST_POP_ONLY_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
    fq_pop |-> !fq_empty); // R9

  AST_ORIG_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |-> (mem_addr[4:0] != 5'd24 && mem_addr[4:0] != 5'd28)); // R3

  AST_TAIL_BEFORE_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    dq_push |-> $past(mem_en && mem_we && mem_wdata == '0 && mem_addr[4:0] == 5'd20)); // R4

  AST_PUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    dq_push |=> (!dq_push && pkt_ready)); // R8

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_ready) |=> !pkt_ready); // R10

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_ready |-> (!mem_en && !fq_pop && !dq_push)); // R1

endmodule

// File: rtl/rxf_engine.sv
module rxf_engine
  import rxf_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pkt_valid,
  output logic                 pkt_ready,
  input  logic [RXF_LEN_W-1:0] pkt_len,
  input  logic [4:0]           pkt_type,
  input  logic                 pkt_ps_loc,
  input  logic                 pkt_epib,
  input  logic [5:0]           pkt_ps_words,
  input  logic                 fq_empty,
  input  logic [RXF_AW-1:0]    fq_desc,
  output logic                 fq_pop,
  output logic                 mem_en,
  output logic                 mem_we,
  output logic [RXF_AW-1:0]    mem_addr,
  output logic [RXF_DW-1:0]    mem_wdata,
  input  logic [RXF_DW-1:0]    mem_rdata,
  output logic                 dq_push,
  output logic [RXF_AW-1:0]    dq_desc,
  output logic [CNT_W-1:0]     starve_cnt
);

  logic                 bud_load, bud_commit, bud_done, starve_wait;
  logic [RXF_LEN_W-1:0] bud_cap, bud_fill;

  rxf_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .pkt_valid    (pkt_valid),
    .pkt_ready    (pkt_ready),
    .pkt_len      (pkt_len),
    .pkt_type     (pkt_type),
    .pkt_ps_loc   (pkt_ps_loc),
    .pkt_epib     (pkt_epib),
    .pkt_ps_words (pkt_ps_words),
    .fq_empty     (fq_empty),
    .fq_desc      (fq_desc),
    .fq_pop       (fq_pop),
    .mem_en       (mem_en),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_rdata    (mem_rdata),
    .dq_push      (dq_push),
    .dq_desc      (dq_desc),
    .bud_load     (bud_load),
    .bud_commit   (bud_commit),
    .bud_cap      (bud_cap),
    .bud_fill     (bud_fill),
    .bud_done     (bud_done),
    .starve_wait  (starve_wait)
  );

  rxf_budget u_budget (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (bud_load),
    .load_len (pkt_len),
    .commit   (bud_commit),
    .cap      (bud_cap),
    .fill     (bud_fill),
    .done     (bud_done)
  );

  rxf_starve #(.CNT_W(CNT_W)) u_starve (
    .clk     (clk),
    .rst_n   (rst_n),
    .waiting (starve_wait),
    .popped  (fq_pop),
    .cnt     (starve_cnt)
  );

endmodule

// File: tb/rxf_engine_tb_top.sv
module rxf_engine_tb_top;

  localparam int NDESC = 24;
  localparam int CNT_W = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pkt_valid = 1'b0;
  logic        pkt_ready;
  logic [21:0] pkt_len = '0;
  logic [4:0]  pkt_type = '0;
  logic        pkt_ps_loc = 1'b0;
  logic        pkt_epib = 1'b0;
  logic [5:0]  pkt_ps_words = '0;
  logic        fq_empty;
  logic [31:0] fq_desc;
  logic        fq_pop;
  logic        mem_en, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        dq_push;
  logic [31:0] dq_desc;
  logic [CNT_W-1:0] starve_cnt;

  always #10 clk = ~clk; // 50 MHz

  rxf_engine #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_len(pkt_len), .pkt_type(pkt_type), .pkt_ps_loc(pkt_ps_loc),
    .pkt_epib(pkt_epib), .pkt_ps_words(pkt_ps_words), .fq_empty(fq_empty),
    .fq_desc(fq_desc), .fq_pop(fq_pop), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .dq_push(dq_push), .dq_desc(dq_desc), .starve_cnt(starve_cnt)
  );

  // descriptor memory model, one-cycle read latency
  logic [31:0] mem [0:511];
  always @(posedge clk) begin
    if (mem_en && mem_we)  mem[mem_addr[10:2]] <= mem_wdata;
    if (mem_en && !mem_we) mem_rdata <= mem[mem_addr[10:2]];
  end

  // free queue model
  logic [31:0] fq_buf [0:63];
  int fq_wr = 0, fq_rd = 0, pop_limit = 1 << 30;
  logic [31:0] plog [0:4095];
  assign fq_empty = (fq_wr == fq_rd) || (fq_rd >= pop_limit);
  assign fq_desc  = fq_buf[fq_rd % 64];
  always @(posedge clk) begin
    if (fq_pop && !fq_empty) begin
      plog[fq_rd] <= fq_desc;
      fq_rd <= fq_rd + 1;
    end
  end

  logic [31:0] orig [0:NDESC-1][0:7];
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit timed_out = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] daddr(input int i);
    return 32'((i + 1) * 32);
  endfunction

  function automatic int didx(input logic [31:0] a);
    return int'(a >> 5) - 1;
  endfunction

  function automatic logic [21:0] min22(input logic [21:0] a, input logic [21:0] b);
    return (a <= b) ? a : b;
  endfunction

  function automatic logic [31:0] exp_hdr(input logic [4:0] t, input logic loc,
                                          input logic [21:0] len);
    return (32'(t) << 25) | (32'(loc) << 22) | 32'(len);
  endfunction

  function automatic logic [31:0] exp_info(input logic e, input logic [5:0] ps,
                                           input logic [31:0] old);
    return (32'(e) << 31) | (32'(ps) << 24) | (old & 32'h0000_ffff);
  endfunction

  task automatic init_desc(input int i);
    for (int w = 0; w < 8; w++) begin
      logic [31:0] v;
      v = $urandom;
      if (w == 6) v = (v & 32'hffc0_0000) | 32'(64 + ($urandom % 137));
      orig[i][w] = v;
      mem[(daddr(i) >> 2) + w] = v;
    end
  endtask

  task automatic enq(input logic [31:0] a);
    fq_buf[fq_wr % 64] = a;
    fq_wr = fq_wr + 1;
  endtask

  task automatic start_pkt(input logic [21:0] len, input logic [4:0] t,
                           input logic loc, input logic e, input logic [5:0] ps);
    @(negedge clk);
    chk(pkt_ready == 1'b1, "R10 ready before accept", 32'(pkt_ready), 1);
    pkt_valid = 1'b1; pkt_len = len; pkt_type = t;
    pkt_ps_loc = loc; pkt_epib = e; pkt_ps_words = ps;
    @(negedge clk);
    pkt_valid = 1'b0;
    chk(pkt_ready == 1'b0, "R10 busy after accept", 32'(pkt_ready), 0);
  endtask

  task automatic wait_push_and_check(input int start, input logic [21:0] len,
      input logic [4:0] t, input logic loc, input logic e, input logic [5:0] ps);
    int waited = 0;
    int n;
    logic [21:0] rest;
    bit early_end = 0;
    while (dq_push !== 1'b1 && waited < 4000) begin
      @(negedge clk);
      waited++;
    end
    if (waited >= 4000) begin
      timed_out = 1;
      chk(1'b0, "R8 push timeout", 0, 1);
      return;
    end
    n = fq_rd - start;
    chk(dq_desc == plog[start], "R8 pushed head", dq_desc, plog[start]);
    chk(n >= 1, "R7 at least one descriptor", 32'(n), 1);
    rest = len;
    for (int k = 0; k < n; k++) begin
      logic [31:0] a;
      int i, b;
      logic [21:0] f;
      a = plog[start + k];
      i = didx(a);
      b = int'(a >> 2);
      f = min22(rest, orig[i][6][21:0]);
      rest = rest - f;
      if (rest == 0 && k != n - 1) early_end = 1;
      chk(mem[b + 3] == 32'(f), "R2 byte count word", mem[b + 3], 32'(f));
      chk(mem[b + 4] == orig[i][7], "R2 buffer pointer word", mem[b + 4], orig[i][7]);
      chk(mem[b + 6] == orig[i][6] && mem[b + 7] == orig[i][7], "R3 saved words kept",
          mem[b + 6], orig[i][6]);
      if (k == n - 1)
        chk(mem[b + 5] == 0, "R4 last link zero", mem[b + 5], 0);
      else
        chk(mem[b + 5] == plog[start + k + 1], "R4 link to next", mem[b + 5],
            plog[start + k + 1]);
      chk(mem[b + 1] == orig[i][1], "R11 word 1 kept", mem[b + 1], orig[i][1]);
      if (k == 0) begin
        chk(mem[b] == exp_hdr(t, loc, len), "R5 head header word", mem[b],
            exp_hdr(t, loc, len));
        chk(mem[b + 2] == exp_info(e, ps, orig[i][2]), "R6 head info word", mem[b + 2],
            exp_info(e, ps, orig[i][2]));
      end else begin
        chk(mem[b] == orig[i][0] && mem[b + 2] == orig[i][2], "R11 non-head words kept",
            mem[b], orig[i][0]);
      end
    end
    chk(rest == 0 && !early_end, "R7 descriptor count fits length", 32'(rest), 0);
    @(negedge clk);
    chk(pkt_ready == 1'b1 && dq_push == 1'b0, "R10 ready after push",
        {30'd0, pkt_ready, dq_push}, 32'h2);
    for (int k = 0; k < n; k++) begin
      init_desc(didx(plog[start + k]));
      enq(plog[start + k]);
    end
  endtask

  task automatic run_pkt(input logic [21:0] len, input logic [4:0] t,
                         input logic loc, input logic e, input logic [5:0] ps);
    int s;
    s = fq_rd;
    start_pkt(len, t, loc, e, ps);
    wait_push_and_check(s, len, t, loc, e, ps);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NDESC; i++) begin
      init_desc(i);
      enq(daddr(i));
    end
    repeat (3) @(negedge clk);
    chk(pkt_ready == 1'b1 && fq_pop == 1'b0 && dq_push == 1'b0 && mem_en == 1'b0,
        "R1 reset outputs", {28'd0, pkt_ready, fq_pop, dq_push, mem_en}, 32'h8);
    chk(starve_cnt == 0, "R1 starvation count reset", 32'(starve_cnt), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7 zero length packet
    begin
      int s;
      s = fq_rd;
      run_pkt(22'd0, 5'd3, 1'b0, 1'b0, 6'd0);
      chk(fq_rd - s == 1, "R7 zero length uses one descriptor", 32'(fq_rd - s), 1);
    end

    // R7 packet exactly one buffer long
    if (!timed_out) begin
      int s;
      logic [21:0] sz;
      s = fq_rd;
      sz = orig[didx(fq_buf[fq_rd % 64])][6][21:0];
      run_pkt(sz, 5'd31, 1'b1, 1'b1, 6'd32);
      chk(fq_rd - s == 1, "R7 exact fit single descriptor", 32'(fq_rd - s), 1);
    end

    // R9 two starvation episodes in mid-chain
    if (!timed_out) begin
      int s;
      logic [CNT_W-1:0] c0;
      c0 = starve_cnt;
      s = fq_rd;
      pop_limit = fq_rd + 1;
      start_pkt(22'd700, 5'd9, 1'b0, 1'b1, 6'd4);
      repeat (30) @(negedge clk);
      chk(fq_rd - s == 1, "R9 no pop while empty", 32'(fq_rd - s), 1);
      chk(pkt_ready == 1'b0 && dq_push == 1'b0, "R9 packet held while starved",
          {30'd0, pkt_ready, dq_push}, 0);
      pop_limit = fq_rd + 1;
      repeat (30) @(negedge clk);
      chk(fq_rd - s == 2, "R9 one pop per release", 32'(fq_rd - s), 2);
      pop_limit = 1 << 30;
      wait_push_and_check(s, 22'd700, 5'd9, 1'b0, 1'b1, 6'd4);
      chk(starve_cnt == c0 + 2, "R9 one count per episode", 32'(starve_cnt),
          32'(c0 + 2));
    end

    // random packets
    for (int p = 0; p < 40 && !timed_out; p++) begin
      logic [21:0] len;
      len = ($urandom % 4 == 0) ? 22'($urandom % 8) : 22'($urandom % 900);
      run_pkt(len, 5'($urandom), 1'($urandom), 1'($urandom), 6'($urandom % 33));
    end

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  // global watchdog
  initial begin
    wait (cyc > 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule